// File: doc/BRIEF.md
# PCI Configuration Address Translator

The translator turns a processor access that lands in a downstream configuration window into a type-0 PCI configuration request. The processor supplies a 16-bit window offset, an access size, a direction and write data. A mapping-register input supplies the upper 16 bits of the configuration address and a mode bit. The two halves are joined into one 32-bit word. The block then splits that word into three fields. The first is a one-hot device-select field, which the block reduces to a device number. The second is the function field. The third is the register field.

From these fields the block builds the enabled bus-side request address and holds the request until the bus side acknowledges it. It then returns read data sized to the access. When a request is actually carried out on the bus, the block pulses a clear to the host bridge's received-abort status bits.

An access is not issued in three cases: the mapping register selects type-1 mode, the alignment is wrong, or no device-select bit is set. In each of these cases a read completes with all-ones of the access size and a write is dropped. The last two cases also raise an error flag.

Top module: `cfg_addr_xlate`

## Requirements
- R1: The formed address takes bits [15:0] from `cpu_offset_i` and bits [31:16] from `map_reg_i[15:0]`.
- R2: The device number is the index, counted from formed bit 11, of the lowest set bit in formed bits [31:11]. Any higher set bits are ignored.
- R3: An issued request address has bit 31 = 1 and bits [30:24] = 0. Bits [23:16] carry `bus_num_i`, [15:11] the device number, [10:8] formed bits [10:8], [7:2] formed bits [7:2], and [1:0] the offset byte position.
- R4: When `map_reg_i[16]` is 1, `pci_req_o` stays low and the access completes without error. A read returns all-ones of the access size, and a write reaches nothing.
- R5: The size encoding is 0 = byte, 1 = halfword, 2 = word, 3 = reserved. A halfword with offset bit 0 set, a word with offset bits [1:0] nonzero, or a reserved size is not issued. It completes with `cpu_err_o` = 1 and read data of all-ones for its size (32 bits for reserved).
- R6: When formed bits [31:11] are all zero, the access is not issued. It completes with `cpu_err_o` = 1 and all-ones read data.
- R7: `abort_clr_o` is high for exactly the one cycle in which an issued request is acknowledged. It never goes high for an access that is not issued.
- R8: `cpu_ready_o` is high only when no access is in progress. `pci_req_o` and its address, size, direction and data stay constant until `pci_ack_i` is seen.
- R9: Read data from an issued access is `pci_rdata_i`, captured on acknowledge and masked to the access size: the low 8 bits for a byte, the low 16 bits for a halfword, all 32 bits for a word.
- R10: `cpu_done_o` pulses for one cycle. For an issued access this is the cycle after the acknowledge; for any other access it is the cycle after acceptance. `cpu_ready_o` returns in the cycle after that.
- R11: After reset, `cpu_ready_o` = 1 and `pci_req_o`, `cpu_done_o`, `cpu_err_o` and `abort_clr_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_valid_i | input | 1 | Processor access request |
| cpu_ready_o | output | 1 | Block idle, access accepted when valid |
| cpu_write_i | input | 1 | 1 = write, 0 = read |
| cpu_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| cpu_offset_i | input | 16 | Offset inside the configuration window |
| cpu_wdata_i | input | 32 | Write data, right-justified |
| map_reg_i | input | 32 | Bits [15:0] upper address half, bit 16 type-1 mode |
| bus_num_i | input | 8 | Bus number placed in the request |
| cpu_done_o | output | 1 | Access completion pulse |
| cpu_err_o | output | 1 | Completion carries an error (valid with done) |
| cpu_rdata_o | output | 32 | Read data, valid with done on reads |
| pci_req_o | output | 1 | Configuration request to the bus side |
| pci_ack_i | input | 1 | Bus side takes the request |
| pci_addr_o | output | 32 | Enabled type-0 configuration address |
| pci_size_o | output | 2 | Access size, same encoding as processor side |
| pci_write_o | output | 1 | Request direction |
| pci_wdata_o | output | 32 | Write data to the bus |
| pci_rdata_i | input | 32 | Read data from the bus, sampled with ack |
| abort_clr_o | output | 1 | Clear received master/target abort status |

## Verification
The bench sets more than one device-select bit, and sets the top bit alone. A design that took the highest set bit, or that miscounted the index, would send the wrong device number. It combines type-1 mode with writes and with every size. A design that leaked these onto the bus, or that returned unsized all-ones, would raise a request or give back the wrong width. Misaligned halfwords, misaligned words, the reserved size and an empty device-select field must each finish without a request and with the error flag set. A design that checked only some of these cases would issue a bus access. The bench also delays the acknowledge by several cycles and counts abort-clear pulses against issued accesses. This catches a request that drops early, changes while waiting, or clears status on a suppressed access.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_RESP  = 2'd2
  } xl_state_e;

  // all-ones pattern of the access width, right-justified
  function automatic logic [31:0] size_ones(logic [1:0] sz);
    case (sz)
      SZ_BYTE: size_ones = 32'h0000_00ff;
      SZ_HALF: size_ones = 32'h0000_ffff;
      default: size_ones = 32'hffff_ffff;
    endcase
  endfunction

endpackage

// File: rtl/cfg_lsb_find.sv
module cfg_lsb_find #(
  parameter int W    = 21,
  parameter int IDXW = $clog2(W)
) (
  input  logic [W-1:0]    vec_i,
  output logic [IDXW-1:0] idx_o,
  output logic            found_o
);

  logic [IDXW-1:0] idx_c;
  logic            found_c;

  // scan downward so the lowest set bit is the last one written
  always_comb begin
    idx_c   = '0;
    found_c = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        idx_c   = IDXW'(i);
        found_c = 1'b1;
      end
    end
  end

  assign idx_o   = idx_c;
  assign found_o = found_c;

endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
  import cfg_xlate_pkg::*;
#(
  parameter int OFF_W     = 16,
  parameter int BUS_W     = 8,
  parameter int SEL_LSB   = 11,
  parameter int MODE_BIT  = 16
) (
  input  logic [OFF_W-1:0]    offset_i,
  input  logic [31:0]         map_i,
  input  logic [BUS_W-1:0]    bus_i,
  input  logic [1:0]          size_i,
  output logic [31:0]         req_addr_o,
  output logic                issue_o,
  output logic                err_o
);

  localparam int HI_W   = 32 - OFF_W;
  localparam int SEL_W  = 32 - SEL_LSB;
  localparam int IDX_W  = $clog2(SEL_W);
  localparam int BUS_SH = 16;
  localparam int DEV_SH = SEL_LSB;

  logic [31:0]      formed;
  logic [IDX_W-1:0] dev_idx;
  logic             sel_found;
  logic             misalign;
  logic             type1;

  assign formed = {map_i[HI_W-1:0], offset_i};
  assign type1  = map_i[MODE_BIT];

  cfg_lsb_find #(.W(SEL_W), .IDXW(IDX_W)) u_lsb (
    .vec_i   (formed[31:SEL_LSB]),
    .idx_o   (dev_idx),
    .found_o (sel_found)
  );

  always_comb begin
    case (size_i)
      SZ_BYTE: misalign = 1'b0;
      SZ_HALF: misalign = formed[0];
      SZ_WORD: misalign = |formed[1:0];
      default: misalign = 1'b1;
    endcase
  end

  assign err_o   = misalign | ~sel_found;
  assign issue_o = ~type1 & ~err_o;

  assign req_addr_o = 32'h8000_0000
                    | (32'(bus_i) << BUS_SH)
                    | (32'(dev_idx) << DEV_SH)
                    | {{(32-SEL_LSB){1'b0}}, formed[SEL_LSB-1:0]};

  logic unused_map;
  assign unused_map = ^map_i[31:MODE_BIT+1];

endmodule

// File: rtl/cfg_xlate_ctrl.sv
module cfg_xlate_ctrl
  import cfg_xlate_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cpu_valid_i,
  input  logic        cpu_write_i,
  input  logic [1:0]  cpu_size_i,
  input  logic [31:0] cpu_wdata_i,
  input  logic [31:0] dec_addr_i,
  input  logic        dec_issue_i,
  input  logic        dec_err_i,
  output logic        cpu_ready_o,
  output logic        cpu_done_o,
  output logic        cpu_err_o,
  output logic [31:0] cpu_rdata_o,
  output logic        pci_req_o,
  input  logic        pci_ack_i,
  output logic [31:0] pci_addr_o,
  output logic [1:0]  pci_size_o,
  output logic        pci_write_o,
  output logic [31:0] pci_wdata_o,
  input  logic [31:0] pci_rdata_i,
  output logic        abort_clr_o
);

  xl_state_e   state_q;
  logic [31:0] addr_q;
  logic [1:0]  size_q;
  logic        write_q;
  logic [31:0] wdata_q;
  logic        err_q;
  logic [31:0] rdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      size_q  <= '0;
      write_q <= 1'b0;
      wdata_q <= '0;
      err_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cpu_valid_i) begin
          addr_q  <= dec_addr_i;
          size_q  <= cpu_size_i;
          write_q <= cpu_write_i;
          wdata_q <= cpu_wdata_i;
          err_q   <= dec_err_i;
          rdata_q <= cpu_write_i ? '0 : size_ones(cpu_size_i);
          state_q <= dec_issue_i ? ST_ISSUE : ST_RESP;
        end
        ST_ISSUE: if (pci_ack_i) begin
          rdata_q <= write_q ? '0 : (pci_rdata_i & size_ones(size_q));
          state_q <= ST_RESP;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready_o = (state_q == ST_IDLE);
  assign pci_req_o   = (state_q == ST_ISSUE);
  assign cpu_done_o  = (state_q == ST_RESP);
  assign cpu_err_o   = cpu_done_o & err_q;
  assign cpu_rdata_o = rdata_q;
  assign pci_addr_o  = addr_q;
  assign pci_size_o  = size_q;
  assign pci_write_o = write_q;
  assign pci_wdata_o = wdata_q;
  assign abort_clr_o = pci_req_o & pci_ack_i;

  a_r8_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_req_o && !pci_ack_i |=> pci_req_o && $stable(pci_addr_o)
                                && $stable(pci_wdata_o) && $stable(pci_write_o))
    else $error("R8 request changed before ack");

  a_r7_clear_then_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_clr_o |=> cpu_done_o && !cpu_err_o)
    else $error("R7 abort clear not followed by completion");

  a_r10_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_done_o |=> cpu_ready_o && !cpu_done_o)
    else $error("R10 done not a single pulse");

  a_r3_enable_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pci_req_o |-> pci_addr_o[31] && (pci_addr_o[30:24] == 7'd0))
    else $error("R3 enable or reserved bits wrong");

  a_r5_err_skips_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_err_o |-> !$past(pci_req_o))
    else $error("R5 errored access reached the bus");

endmodule

// File: rtl/cfg_addr_xlate.sv
module cfg_addr_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int OFF_W    = 16,
  parameter int BUS_W    = 8,
  parameter int SEL_LSB  = 11,
  parameter int MODE_BIT = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_valid_i,
  output logic              cpu_ready_o,
  input  logic              cpu_write_i,
  input  logic [1:0]        cpu_size_i,
  input  logic [OFF_W-1:0]  cpu_offset_i,
  input  logic [31:0]       cpu_wdata_i,
  input  logic [31:0]       map_reg_i,
  input  logic [BUS_W-1:0]  bus_num_i,
  output logic              cpu_done_o,
  output logic              cpu_err_o,
  output logic [31:0]       cpu_rdata_o,
  output logic              pci_req_o,
  input  logic              pci_ack_i,
  output logic [31:0]       pci_addr_o,
  output logic [1:0]        pci_size_o,
  output logic              pci_write_o,
  output logic [31:0]       pci_wdata_o,
  input  logic [31:0]       pci_rdata_i,
  output logic              abort_clr_o
);

  logic [31:0] dec_addr;
  logic        dec_issue;
  logic        dec_err;

  cfg_field_decode #(
    .OFF_W(OFF_W), .BUS_W(BUS_W), .SEL_LSB(SEL_LSB), .MODE_BIT(MODE_BIT)
  ) u_decode (
    .offset_i   (cpu_offset_i),
    .map_i      (map_reg_i),
    .bus_i      (bus_num_i),
    .size_i     (cpu_size_i),
    .req_addr_o (dec_addr),
    .issue_o    (dec_issue),
    .err_o      (dec_err)
  );

  cfg_xlate_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cpu_valid_i (cpu_valid_i),
    .cpu_write_i (cpu_write_i),
    .cpu_size_i  (cpu_size_i),
    .cpu_wdata_i (cpu_wdata_i),
    .dec_addr_i  (dec_addr),
    .dec_issue_i (dec_issue),
    .dec_err_i   (dec_err),
    .cpu_ready_o (cpu_ready_o),
    .cpu_done_o  (cpu_done_o),
    .cpu_err_o   (cpu_err_o),
    .cpu_rdata_o (cpu_rdata_o),
    .pci_req_o   (pci_req_o),
    .pci_ack_i   (pci_ack_i),
    .pci_addr_o  (pci_addr_o),
    .pci_size_o  (pci_size_o),
    .pci_write_o (pci_write_o),
    .pci_wdata_o (pci_wdata_o),
    .pci_rdata_i (pci_rdata_i),
    .abort_clr_o (abort_clr_o)
  );

  a_r4_mode_blocks_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_i && cpu_ready_o && map_reg_i[MODE_BIT] |=> !pci_req_o)
    else $error("R4 type-1 mode access issued");

  a_r6_empty_sel_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_valid_i && cpu_ready_o && ({map_reg_i[31-OFF_W:0], cpu_offset_i[OFF_W-1:SEL_LSB]} == '0)
    |=> cpu_err_o && !pci_req_o)
    else $error("R6 empty select not flagged");

endmodule

// File: tb/cfg_addr_xlate_bench.sv
module cfg_addr_xlate_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_valid = 1'b0;
  logic        cpu_ready;
  logic        cpu_write = 1'b0;
  logic [1:0]  cpu_size = 2'd0;
  logic [15:0] cpu_offset = '0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] map_reg = '0;
  logic [7:0]  bus_num = '0;
  logic        cpu_done;
  logic        cpu_err;
  logic [31:0] cpu_rdata;
  logic        pci_req;
  logic        pci_ack = 1'b0;
  logic [31:0] pci_addr;
  logic [1:0]  pci_size;
  logic        pci_write;
  logic [31:0] pci_wdata;
  logic [31:0] pci_rdata = '0;
  logic        abort_clr;

  int checks = 0;
  int errors = 0;
  int issued_exp = 0;
  int clr_seen = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  cfg_addr_xlate u_cfg_addr_xlate (
    .clk_i(clk), .rst_ni(rst_n),
    .cpu_valid_i(cpu_valid), .cpu_ready_o(cpu_ready), .cpu_write_i(cpu_write),
    .cpu_size_i(cpu_size), .cpu_offset_i(cpu_offset), .cpu_wdata_i(cpu_wdata),
    .map_reg_i(map_reg), .bus_num_i(bus_num),
    .cpu_done_o(cpu_done), .cpu_err_o(cpu_err), .cpu_rdata_o(cpu_rdata),
    .pci_req_o(pci_req), .pci_ack_i(pci_ack), .pci_addr_o(pci_addr),
    .pci_size_o(pci_size), .pci_write_o(pci_write), .pci_wdata_o(pci_wdata),
    .pci_rdata_i(pci_rdata), .abort_clr_o(abort_clr)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] ones_of(input logic [1:0] sz);
    if (sz == 2'd0) return 32'hff;
    if (sz == 2'd1) return 32'hffff;
    return 32'hffff_ffff;
  endfunction

  // behavioural reference of the request decision and address
  task automatic ref_model(input logic [15:0] off, input logic [31:0] map, input logic [1:0] sz,
                           input logic [7:0] bus, output bit issue, output bit err,
                           output logic [31:0] paddr);
    logic [31:0] formed;
    int dev;
    bit mis;
    formed = {map[15:0], off};
    dev = -1;
    for (int b = 11; b < 32; b++) if (formed[b] && dev < 0) dev = b - 11;
    mis = (sz == 2'd3) || (sz == 2'd1 && off[0]) || (sz == 2'd2 && off[1:0] != 2'd0);
    err = mis || (dev < 0);
    issue = !map[16] && !err;
    paddr = 32'h8000_0000 + (32'(bus) << 16) + (dev < 0 ? 32'd0 : (32'(dev) << 11))
          + {21'd0, formed[10:0]};
  endtask

  task automatic access(input string req, input bit w, input logic [1:0] sz,
                        input logic [15:0] off, input logic [31:0] wd, input logic [31:0] map,
                        input logic [7:0] bus, input logic [31:0] rd, input int delay);
    bit issue, err;
    logic [31:0] paddr, exp_rd;
    ref_model(off, map, sz, bus, issue, err, paddr);
    chk(cpu_ready === 1'b1, {req, " R8 ready before access"}, 32'(cpu_ready), 32'd1);
    cpu_valid = 1'b1; cpu_write = w; cpu_size = sz; cpu_offset = off;
    cpu_wdata = wd; map_reg = map; bus_num = bus;
    @(negedge clk);
    cpu_valid = 1'b0;
    if (issue) begin
      issued_exp++;
      for (int d = 0; d < delay; d++) begin
        chk(pci_req === 1'b1, {req, " R8 req held"}, 32'(pci_req), 32'd1);
        chk(cpu_ready === 1'b0, {req, " R8 busy"}, 32'(cpu_ready), 32'd0);
        @(negedge clk);
      end
      chk(pci_req === 1'b1, {req, " R8 req"}, 32'(pci_req), 32'd1);
      chk(pci_addr === paddr, {req, " R1 R2 R3 address"}, pci_addr, paddr);
      chk(pci_size === sz, {req, " R3 size"}, 32'(pci_size), 32'(sz));
      chk(pci_write === w, {req, " R3 dir"}, 32'(pci_write), 32'(w));
      if (w) chk(pci_wdata === wd, {req, " R3 wdata"}, pci_wdata, wd);
      pci_ack = 1'b1; pci_rdata = rd;
      #1;
      chk(abort_clr === 1'b1, {req, " R7 clear with ack"}, 32'(abort_clr), 32'd1);
      @(negedge clk);
      pci_ack = 1'b0;
      exp_rd = rd & ones_of(sz);
    end else begin
      chk(pci_req === 1'b0, {req, " R4 R5 R6 no request"}, 32'(pci_req), 32'd0);
      exp_rd = ones_of(sz);
    end
    chk(cpu_done === 1'b1, {req, " R10 done"}, 32'(cpu_done), 32'd1);
    chk(cpu_err === err, {req, " R5 R6 error flag"}, 32'(cpu_err), 32'(err));
    if (!w) chk(cpu_rdata === exp_rd, {req, " R9 read data"}, cpu_rdata, exp_rd);
    @(negedge clk);
    chk(cpu_done === 1'b0, {req, " R10 single done"}, 32'(cpu_done), 32'd0);
    chk(cpu_ready === 1'b1, {req, " R10 ready back"}, 32'(cpu_ready), 32'd1);
  endtask

  always @(posedge clk) begin
    if (rst_n && !finished) begin
      if (abort_clr) clr_seen++;
      chk(!(cpu_ready && pci_req), "R8 ready with request", 32'(pci_req), 32'd0);
    end
  end

  initial begin
    #(8 * 100000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cpu_ready === 1'b1, "R11 ready in reset", 32'(cpu_ready), 32'd1);
    chk(pci_req === 1'b0 && cpu_done === 1'b0 && abort_clr === 1'b0 && cpu_err === 1'b0,
        "R11 outputs quiet in reset", {28'd0, pci_req, cpu_done, abort_clr, cpu_err}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // issued accesses
    access("word read dev11",       1'b0, 2'd2, 16'h0104, 32'h0,         32'h0000_0040, 8'h00, 32'h1234_5678, 0);
    access("byte write offset3",    1'b1, 2'd0, 16'h0a03, 32'h0000_00a5, 32'h0000_0001, 8'h03, 32'h0,         2);
    access("half read multi-sel",   1'b0, 2'd1, 16'h0f3e, 32'h0,         32'h0000_0030, 8'h5a, 32'hdead_beef, 1);
    access("word read top bit R2",  1'b0, 2'd2, 16'h00fc, 32'h0,         32'h0000_8000, 8'hff, 32'hcafe_f00d, 3);
    access("byte read mask R9",     1'b0, 2'd0, 16'h0802, 32'h0,         32'h0000_0000, 8'h01, 32'haabb_ccdd, 0);
    access("word write R3",         1'b1, 2'd2, 16'hf710, 32'h0bad_cafe, 32'h0000_0000, 8'h10, 32'h0,         1);
    // type-1 mode R4
    access("type1 word read R4",    1'b0, 2'd2, 16'h0100, 32'h0,         32'h0001_0040, 8'h00, 32'h0,         0);
    access("type1 byte read R4",    1'b0, 2'd0, 16'h0101, 32'h0,         32'h0001_0040, 8'h00, 32'h0,         0);
    access("type1 half read R4",    1'b0, 2'd1, 16'h0102, 32'h0,         32'h0001_0040, 8'h00, 32'h0,         0);
    access("type1 write R4",        1'b1, 2'd2, 16'h0100, 32'h1111_2222, 32'h0001_0040, 8'h00, 32'h0,         0);
    // alignment R5
    access("half misaligned R5",    1'b0, 2'd1, 16'h0801, 32'h0,         32'h0000_0000, 8'h00, 32'h0,         0);
    access("word misaligned R5",    1'b0, 2'd2, 16'h0802, 32'h0,         32'h0000_0000, 8'h00, 32'h0,         0);
    access("reserved size R5",      1'b0, 2'd3, 16'h0800, 32'h0,         32'h0000_0000, 8'h00, 32'h0,         0);
    access("misaligned write R5",   1'b1, 2'd1, 16'h0803, 32'h5555_5555, 32'h0000_0000, 8'h00, 32'h0,         0);
    // empty select R6
    access("empty select R6",       1'b0, 2'd2, 16'h0004, 32'h0,         32'h0000_0000, 8'h00, 32'h0,         0);
    access("empty sel write R6",    1'b1, 2'd0, 16'h07ff, 32'h0000_0011, 32'h0000_0000, 8'h00, 32'h0,         0);
    access("after errors word R9",  1'b0, 2'd2, 16'h2000, 32'h0,         32'h0000_0000, 8'h07, 32'h0f0f_0f0f, 4);
    @(negedge clk);
    chk(clr_seen == issued_exp, "R7 abort clear count", 32'(clr_seen), 32'(issued_exp));
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule